// File: doc/BRIEF.md
# Bidirectional Pattern Frequency Detector

This block compares the rate of a serial data stream with a half-rate recovered clock and tells the loop whether the clock must speed up or slow down. A fast system clock samples four single-bit inputs: the data, the in-phase recovered clock, the quadrature recovered clock and an acquisition enable. All four are treated as synchronous samples, with at least eight samples per data bit. A change between a sample and the previous sample counts as an edge.

The block has two detectors for each clock phase. The increment detector fires when one high half-period of that phase holds two or more data edges. An isolated 0-1-0 or 1-0-1 bit inside one half-period means the clock is too slow. The decrement detector fires when a steady high data bit encloses a whole clock pulse, as in 0-1-0 or 0-1-1 data. That means the clock is too fast. The decrement request then stays asserted until the enclosing data bit ends, so its width grows with the frequency error.

Long runs in the data can make a slow clock look fast. To prevent this, a steering flag is set by the first increment request and from then on blocks every decrement request. Taking the enable low clears the flag and all detector state. The charge pump, the loop filter and the oscillator are outside this block.

Top module: `bidir_freq_det`

## Requirements
- R1: While `acq_en` is sampled low, all detector state and the steering flag are cleared, and in the next cycle both `inc` and `dec` are 0. After reset both outputs are 0.
- R2: For each phase, a data edge is counted only in a sample where that phase is high and was also high in the previous sample. The count restarts at the sample where the phase rises.
- R3: When a phase is first sampled low after being high, and two or more data edges were counted in that high period, `inc` is 1 for exactly the one cycle after that sample.
- R4: The in-phase and quadrature clocks each have their own increment detector. Either one can raise `inc` alone. Data shaped 0-1-0 and data shaped 1-0-1 both qualify.
- R5: A phase arms its decrement detector when it rises while the data is high in both the current and the previous sample. Any data edge before the phase falls disarms it. A fall that is still armed, with the data still high, starts a decrement request in the next cycle.
- R6: A decrement request lasts until the cycle after the first sample in which the data goes from 1 to 0. `dec` is 1 while either phase holds a request, the steering flag is clear and `inc` is 0.
- R7: The steering flag is set in the cycle after `inc` is 1, and it stays set until `acq_en` is low. While it is set, `dec` is 0.
- R8: `inc` and `dec` are never 1 in the same cycle. When both would assert, `inc` wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acq_en | input | 1 | Acquisition enable; low clears the steering flag and all detectors |
| data_s | input | 1 | Sampled serial data |
| rck_i | input | 1 | Sampled in-phase recovered clock |
| rck_q | input | 1 | Sampled quadrature recovered clock |
| inc | output | 1 | Clock-too-slow request, one-cycle pulse |
| dec | output | 1 | Clock-too-fast request, width tracks the frequency error |

## Verification
The hardest state to reach from the ports is a decrement request that must be suppressed. A fast clock against long runs has to first show free decrement pulses. The same decrement stimulus must then go quiet once one increment has set the steering flag. It must come back only after a low pulse on the enable.

The stimulus reaches this state in stages. It plays long-run data under a fast clock, then an isolated-bit pattern under a slow clock, then the long-run pattern again, then an enable drop, and then the long runs once more. A separate segment holds the in-phase clock low, so that the quadrature detector must produce the increment alone.

// File: rtl/bidir_freq_det.sv
module bidir_freq_det #(
  parameter int NPH   = 2,
  parameter int ECW   = 2,
  parameter int MINE  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acq_en,
  input  logic data_s,
  input  logic rck_i,
  input  logic rck_q,
  output logic inc,
  output logic dec
);
  localparam logic [ECW-1:0] EMAX = {ECW{1'b1}};
  localparam logic [ECW-1:0] ETHR = ECW'(MINE);

  logic [NPH-1:0] ck, ck_d, rise, fall, up_hit, hold;
  logic           dat_d, dedge, dfall, steer;

  assign ck    = NPH'({rck_q, rck_i});
  assign rise  = ck & ~ck_d;
  assign fall  = ~ck & ck_d;
  assign dedge = data_s ^ dat_d;
  assign dfall = dat_d & ~data_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_d  <= '0;
      dat_d <= 1'b0;
    end else begin
      ck_d  <= ck;
      dat_d <= data_s;
    end
  end

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic [ECW-1:0] ecnt;
    logic           armed;

    assign up_hit[p] = fall[p] && (ecnt >= ETHR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ecnt    <= '0;
        armed   <= 1'b0;
        hold[p] <= 1'b0;
      end else if (!acq_en) begin
        ecnt    <= '0;
        armed   <= 1'b0;
        hold[p] <= 1'b0;
      end else begin
        if (rise[p])
          ecnt <= '0;
        else if (ck[p] && ck_d[p] && dedge && ecnt != EMAX)
          ecnt <= ecnt + 1'b1;

        if (rise[p])
          armed <= data_s & dat_d;
        else if (dedge || fall[p])
          armed <= 1'b0;

        if (fall[p] && armed && data_s)
          hold[p] <= 1'b1;
        else if (dfall)
          hold[p] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inc   <= 1'b0;
      steer <= 1'b0;
    end else if (!acq_en) begin
      inc   <= 1'b0;
      steer <= 1'b0;
    end else begin
      inc <= |up_hit;
      if (inc) steer <= 1'b1;
    end
  end

  assign dec = (|hold) & ~steer & ~inc;

endmodule

// File: rtl/bidir_freq_det_chk.sv
module bidir_freq_det_chk (
  input logic clk,
  input logic rst_n,
  input logic acq_en,
  input logic data_s,
  input logic rck_i,
  input logic rck_q,
  input logic inc,
  input logic dec
);
  logic seen_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_inc <= 1'b0;
    else if (!acq_en) seen_inc <= 1'b0;
    else if (inc)     seen_inc <= 1'b1;
  end

  // R8
  never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc && dec));

  // R7
  steer_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_inc |-> !dec);

  // R1
  en_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acq_en |=> (!inc && !dec));

  // R3
  inc_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inc |-> (($past(rck_i, 2) && !$past(rck_i)) || ($past(rck_q, 2) && !$past(rck_q))));

  // R5
  dec_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dec) |-> $past(data_s));
endmodule

bind bidir_freq_det bidir_freq_det_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .data_s(data_s),
  .rck_i(rck_i), .rck_q(rck_q), .inc(inc), .dec(dec)
);

// File: tb/bidir_freq_det_test.sv
`timescale 1ns/1ps
module bidir_freq_det_test;
  logic clk = 1'b0, rst_n = 1'b0, acq_en = 1'b0, data_s = 1'b0, rck_i = 1'b0, rck_q = 1'b0;
  logic inc, dec;
  int   n_chk = 0, n_fail = 0, t = 0;
  int   cyc = 0;
  bit   done = 0;

  always #4 clk = ~clk;

  bidir_freq_det uut (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .data_s(data_s),
    .rck_i(rck_i), .rck_q(rck_q), .inc(inc), .dec(dec)
  );

  // Reference model
  bit m_ckd[2], m_arm[2], m_hold[2];
  int m_cnt[2];
  bit m_dind, m_up, m_sw, nup;
  bit c, r, f, e;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_ckd[p] = 0; m_arm[p] = 0; m_hold[p] = 0; m_cnt[p] = 0;
      end
      m_dind = 0; m_up = 0; m_sw = 0;
    end else begin
      nup = 0;
      e = (data_s != m_dind);
      for (int p = 0; p < 2; p++) begin
        c = (p == 0) ? rck_i : rck_q;
        r = c && !m_ckd[p];
        f = !c && m_ckd[p];
        if (!acq_en) begin
          m_cnt[p] = 0; m_arm[p] = 0; m_hold[p] = 0;
        end else begin
          if (f && m_cnt[p] >= 2) nup = 1;
          if (f && m_arm[p] && data_s) m_hold[p] = 1;
          else if (m_dind && !data_s) m_hold[p] = 0;
          if (r) m_cnt[p] = 0;
          else if (c && m_ckd[p] && e && m_cnt[p] < 3) m_cnt[p]++;
          if (r) m_arm[p] = data_s && m_dind;
          else if (e || f) m_arm[p] = 0;
        end
        m_ckd[p] = c;
      end
      if (!acq_en) begin
        m_sw = 0; m_up = 0;
      end else begin
        if (m_up) m_sw = 1;
        m_up = nup;
      end
      m_dind = data_s;
    end
  end

  function automatic bit exp_dec();
    return (m_hold[0] || m_hold[1]) && !m_sw && !m_up;
  endfunction

  int seg_up, seg_dn;

  task automatic check(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", req, t, act, expv);
    end
  endtask

  task automatic step(input bit ci, input bit cq, input bit d, input bit en);
    @(negedge clk);
    check("R3/R4 inc", inc, m_up);
    check("R6/R7 dec", dec, exp_dec());
    check("R8 exclusive", int'(inc && dec), 0);
    seg_up += inc;
    seg_dn += dec;
    rck_i = ci; rck_q = cq; data_s = d; acq_en = en;
    t++;
  endtask

  // mode 0: alternating bits; mode 1: runs of two 1s then two 0s
  task automatic run(input int n, input int cper, input int dbit, input int doff,
                     input int mode, input bit i_on, input bit en);
    seg_up = 0; seg_dn = 0;
    for (int k = 0; k < n; k++) begin
      int bi;
      bit d, ci, cq;
      bi = (k + doff) / dbit;
      d  = (mode == 0) ? bi[0] : ((bi % 4) < 2);
      ci = i_on && ((k % cper) < cper / 2);
      cq = (((k + cper / 4) % cper) < cper / 2);
      step(ci, cq, d, en);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset inc", inc, 0);
    check("R1 reset dec", dec, 0);
    rst_n = 1'b1;
    step(0, 0, 0, 1);

    // R5 R6: fast clock, long runs -> dec only
    run(640, 8, 16, 0, 1, 1, 1);
    check("R5 dec seen (fast clk)", int'(seg_dn > 0), 1);
    check("R5 no inc (fast clk)", seg_up, 0);

    // R3 R4: slow clock, alternating data -> inc only
    run(640, 32, 8, 3, 0, 1, 1);
    check("R3 inc seen (slow clk)", int'(seg_up > 0), 1);
    check("R3 no dec (slow clk)", seg_dn, 0);

    // R7: long runs again, steering blocks dec
    run(640, 8, 16, 0, 1, 1, 1);
    check("R7 dec blocked after inc", seg_dn, 0);

    // R1: enable low clears steering
    run(8, 8, 16, 0, 1, 1, 0);
    check("R1 quiet while disabled", seg_up + seg_dn, 0);
    run(640, 8, 16, 0, 1, 1, 1);
    check("R7 dec back after enable drop", int'(seg_dn > 0), 1);

    // R4: quadrature phase alone
    run(640, 32, 8, 3, 0, 0, 1);
    check("R4 inc from quadrature alone", int'(seg_up > 0), 1);

    // R2: edge on rising sample not counted (edges land at 0 and 16 only)
    run(320, 32, 16, 0, 0, 1, 1);
    check("R2 boundary edges give no inc", seg_up, 0);

    done = 1;
  end

  initial begin
    while (!done && cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog t=%0d actual=%0d expected=%0d", t, 0, 1);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule